// File: doc/BRIEF.md
# DMA Status Flag Register

This block is the status register of a DMA controller that walks command packets. It is eight bits wide and software can only read it. The DMA engine sends it one-cycle event pulses: normal command completion, completion of a halt, a timed-out access to a peripheral slot, a local-bus error during a command fetch, a local-bus error acknowledge, and detection of a command's chain-interrupt bit. Each pulse sets its own sticky flag, and the flag stays set until one of its clear paths fires.

An enable strobe from the controller clears every flag, so each run starts with a clean status word. The chain-interrupt flag has two more clear paths: a clear of the interrupt status, and a halt. A summary interrupt-pending bit merges the flags that can raise an interrupt and is gated by an interrupt enable. That bit also drives the block's single interrupt request line.

Top module: `dma_stat_reg`

## Requirements
- R1: Synchronous active-low reset makes the register read 0x01: done set, every other bit clear.
- R2: The field positions are bit 0 done, bit 1 slot timeout, bit 2 fetch error, bit 3 chain interrupt, bit 4 interrupt pending and bit 6 local-bus error. Bits 5 and 7 always read 0.
- R3: A command-done pulse or a halt-done pulse sets the done bit on the next clock.
- R4: A slot-timeout pulse sets bit 1 on the next clock.
- R5: A fetch-error pulse sets both bit 2 and bit 6 on the next clock.
- R6: A bus-error pulse sets bit 6 only on the next clock.
- R7: A set flag holds its value across idle cycles until one of its clear paths fires.
- R8: An enable strobe clears every flag on the next clock. It wins over any set pulse in the same cycle.
- R9: A chain pulse sets bit 3. Bit 3 clears on an interrupt-status clear or a halt-done pulse, and either clear wins over a chain pulse in the same cycle.
- R10: Bit 4 reads 1 exactly when the interrupt enable is 1 and at least one of done, slot timeout, local-bus error or chain interrupt is set. The fetch-error bit on its own does not count.
- R11: The interrupt request output equals bit 4. It is 0 whenever the interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Controller enable strobe; clears all flags |
| ev_cmd_done | input | 1 | Commands finished without error |
| ev_halt_done | input | 1 | Controller stopped on a halt request |
| ev_slot_timeout | input | 1 | Peripheral slot access timed out |
| ev_fetch_err | input | 1 | Local-bus error while fetching command words |
| ev_bus_err | input | 1 | Local-bus transfer error acknowledge |
| ev_chain_irq | input | 1 | Command interrupt-enable bit detected |
| irq_enable | input | 1 | Interrupt enable |
| irq_stat_clr | input | 1 | Interrupt status clear strobe |
| rd_value | output | 8 | Register read value |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench targets set-versus-clear collisions. An enable strobe arriving together with a set pulse must leave the flag clear; a design that lets the set win would report stale status at the start of a new run. A chain pulse that meets a halt or a status clear must also lose; if it wins, the interrupt line stays stuck high. The bench checks that a fetch error on its own raises the interrupt only through the local-bus error bit it also sets; a design that set bit 2 alone would miss that interrupt. It also checks that the done bit comes out of reset set while the interrupt stays masked until the enable rises; a design that reset done to 0 would read 0x00 after reset instead of 0x01. A pseudo-random phase then compares every cycle against a behavioural model.

// File: rtl/dma_stat_pkg.sv
// Package: dma_stat_pkg
// Shared constants for the DMA status register. Flags are numbered
// internally 0..NFLAG-1. flag_pos() maps each flag to its bit in the read
// word, because software decodes those positions.
package dma_stat_pkg;
    localparam int REG_W = 8;
    localparam int NFLAG = 5;

    // internal flag indices
    localparam int F_DONE  = 0;
    localparam int F_TMO   = 1;
    localparam int F_FETCH = 2;
    localparam int F_CHAIN = 3;
    localparam int F_LBE   = 4;

    // read-word bit positions
    localparam int POS_DONE  = 0;
    localparam int POS_TMO   = 1;
    localparam int POS_FETCH = 2;
    localparam int POS_CHAIN = 3;
    localparam int POS_PEND  = 4;
    localparam int POS_LBE   = 6;

    // reset value per flag: only done starts set
    localparam logic [NFLAG-1:0] FLAG_RST = 5'b00001;
    // flags that feed the interrupt-pending summary
    localparam logic [NFLAG-1:0] IRQ_SRC  = 5'b11011;

    // Map an internal flag index to its bit in the read word.
    function automatic int flag_pos(input int idx);
        case (idx)
            F_DONE:  return POS_DONE;
            F_TMO:   return POS_TMO;
            F_FETCH: return POS_FETCH;
            F_CHAIN: return POS_CHAIN;
            default: return POS_LBE;
        endcase
    endfunction
endpackage

// File: rtl/dma_stat_flag.sv
// Module: dma_stat_flag
// One sticky status bit. Clear has priority over set. Reset loads RST_VAL.
// Assumes set and clr are synchronous single-cycle qualifiers.
module dma_stat_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, set or clear the flag; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
    assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> q);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
endmodule

// File: rtl/dma_stat_irq.sv
// Module: dma_stat_irq
// Merges the interrupt-capable flags into the pending summary and gates the
// result with the interrupt enable. Purely combinational.
module dma_stat_irq
    import dma_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags,
    input  logic             irq_enable,
    output logic             pend
);
    // OR the masked sources and apply the enable.
    always_comb pend = irq_enable & (|(flags & IRQ_SRC));

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |-> !pend);
endmodule

// File: rtl/dma_stat_pack.sv
// Module: dma_stat_pack
// Places the flags and the pending bit at their read-word positions.
// Reserved positions are tied to zero.
module dma_stat_pack
    import dma_stat_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic             pend,
    output logic [REG_W-1:0] word
);
    // Scatter flag bits into the read word.
    always_comb begin
        word = '0;
        for (int i = 0; i < NFLAG; i++) word[flag_pos(i)] = flags[i];
        word[POS_PEND] = pend;
    end
endmodule

// File: rtl/dma_stat_reg.sv
// Module: dma_stat_reg
// Read-only DMA status register. Holds sticky event flags with per-flag set
// causes and a shared clear-on-enable, and drives the interrupt request.
// Assumes all event inputs are synchronous to clk.
module dma_stat_reg
    import dma_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_enable,
    input  logic             ev_cmd_done,
    input  logic             ev_halt_done,
    input  logic             ev_slot_timeout,
    input  logic             ev_fetch_err,
    input  logic             ev_bus_err,
    input  logic             ev_chain_irq,
    input  logic             irq_enable,
    input  logic             irq_stat_clr,
    output logic [REG_W-1:0] rd_value,
    output logic             irq_req
);
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flags;
    logic             pend;

    // Decode each flag's set cause.
    always_comb begin
        set_v          = '0;
        set_v[F_DONE]  = ev_cmd_done | ev_halt_done;
        set_v[F_TMO]   = ev_slot_timeout;
        set_v[F_FETCH] = ev_fetch_err;
        set_v[F_CHAIN] = ev_chain_irq;
        set_v[F_LBE]   = ev_bus_err | ev_fetch_err;
    end

    // Decode clear paths: enable clears all; chain also clears on status clear or halt.
    always_comb begin
        clr_v          = {NFLAG{ctl_enable}};
        clr_v[F_CHAIN] = ctl_enable | irq_stat_clr | ev_halt_done;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        dma_stat_flag #(.RST_VAL(FLAG_RST[g])) u_flag (
            .clk(clk), .rst_n(rst_n), .set(set_v[g]), .clr(clr_v[g]), .q(flags[g])
        );
    end

    dma_stat_irq u_irq (
        .clk(clk), .rst_n(rst_n), .flags(flags), .irq_enable(irq_enable), .pend(pend)
    );

    dma_stat_pack u_pack (.flags(flags), .pend(pend), .word(rd_value));

    // Drive the interrupt line from the pending summary.
    always_comb irq_req = pend;

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_value & ~(8'h1 << POS_PEND)) == 8'h01);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_value[7] == 1'b0 && rd_value[5] == 1'b0);
    assert_enable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_enable |=> rd_value == '0);
    assert_fetch_sets_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fetch_err && !ctl_enable) |=> (rd_value[POS_FETCH] && rd_value[POS_LBE]));
    assert_chain_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat_clr || ev_halt_done) |=> !rd_value[POS_CHAIN]);
endmodule

// File: tb/dma_stat_reg_test.sv
module dma_stat_reg_test;
    logic clk = 1'b0;
    logic rst_n, en, cmd, halt, tmo, fe, be, ch, ie, sclr;
    logic [7:0] rd_value;
    logic irq_req;
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    bit m_done, m_tmo, m_fe, m_ch, m_lbe;

    always #4 clk = ~clk;

    dma_stat_reg uut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(en), .ev_cmd_done(cmd),
        .ev_halt_done(halt), .ev_slot_timeout(tmo), .ev_fetch_err(fe),
        .ev_bus_err(be), .ev_chain_irq(ch), .irq_enable(ie),
        .irq_stat_clr(sclr), .rd_value(rd_value), .irq_req(irq_req)
    );

    function automatic bit m_pend();
        return ie && (m_done || m_tmo || m_lbe || m_ch);
    endfunction

    function automatic logic [7:0] m_word();
        return {1'b0, m_lbe, 1'b0, m_pend(), m_ch, m_fe, m_tmo, m_done};
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: apply inputs, advance the model at the edge, compare after it.
    task automatic step(string req, bit r, bit e, bit c, bit h, bit t, bit f,
                        bit b, bit k, bit i, bit s);
        rst_n = r; en = e; cmd = c; halt = h; tmo = t; fe = f; be = b; ch = k;
        ie = i; sclr = s;
        @(posedge clk);
        if (!r) begin
            {m_done, m_tmo, m_fe, m_ch, m_lbe} = 5'b10000;
        end else if (e) begin
            {m_done, m_tmo, m_fe, m_ch, m_lbe} = 5'b00000;
        end else begin
            if (c || h) m_done = 1;
            if (t) m_tmo = 1;
            if (f) begin m_fe = 1; m_lbe = 1; end
            if (b) m_lbe = 1;
            if (s || h) m_ch = 0;
            else if (k) m_ch = 1;
        end
        #2;
        check(req, "rd_value", rd_value, m_word());
        check(r ? "R11" : req, "irq_req", {7'b0, irq_req}, {7'b0, m_pend()});
        check("R2", "reserved", {6'b0, rd_value[7], rd_value[5]}, 8'h00);
    endtask

    task automatic idle(string req, bit i, int n);
        for (int j = 0; j < n; j++) step(req, 1, 0, 0, 0, 0, 0, 0, 0, i, 0);
    endtask

    task automatic enable(bit i);
        step("R8", 1, 1, 0, 0, 0, 0, 0, 0, i, 0);
    endtask

    initial begin
        // R1: reset value
        for (int j = 0; j < 3; j++) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle("R1", 0, 2);                                  // 0x01, irq masked
        idle("R10", 1, 1);                                 // 0x11, irq high
        enable(1);                                         // R8 clears all
        step("R8", 1, 1, 1, 0, 1, 1, 1, 1, 1, 0);          // enable beats sets
        step("R3", 1, 0, 1, 0, 0, 0, 0, 0, 1, 0);          // cmd done
        idle("R7", 1, 3);                                  // sticky
        enable(1);
        step("R3", 1, 0, 0, 1, 0, 0, 0, 0, 1, 0);          // halt done
        enable(1);
        step("R4", 1, 0, 0, 0, 1, 0, 0, 0, 1, 0);          // slot timeout
        idle("R7", 1, 2);
        enable(1);
        step("R5", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);          // fetch err, masked
        idle("R10", 1, 1);                                 // pend via bit 6
        enable(1);
        step("R6", 1, 0, 0, 0, 0, 0, 1, 0, 1, 0);          // bus err only
        enable(0);
        step("R9", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0);          // chain, irq masked
        idle("R11", 0, 1);
        idle("R10", 1, 1);
        step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 1, 1);          // status clear
        step("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        step("R9", 1, 0, 0, 1, 0, 0, 0, 0, 1, 0);          // halt clears chain
        step("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1, 1);          // clear beats chain
        enable(1);
        step("R9", 1, 0, 0, 1, 0, 0, 0, 1, 1, 0);          // halt beats chain
        step("R4", 1, 0, 0, 0, 1, 0, 1, 0, 1, 0);
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);          // reset mid-run
        idle("R1", 1, 1);
        // R7: pseudo-random phase compared every clock against the model
        begin
            logic [15:0] lf = 16'hACE1;
            for (int n = 0; n < 600; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step("R7", 1, lf[0] & lf[5] & lf[9], lf[1] & lf[6], lf[2] & lf[7] & lf[3],
                     lf[3] & lf[8], lf[4] & lf[11] & lf[2], lf[5] & lf[12],
                     lf[6] & lf[13], lf[14] | lf[7], lf[15] & lf[10]);
            end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule